// File: doc/BRIEF.md
# PCI Target Slave Interface

This block is the target side of a single-function PCI device. It watches the shared address/data and command/byte-enable lines together with FRAME# and IRDY#. It claims three kinds of access: Type 0 configuration cycles, single-data-phase I/O accesses and single-data-phase memory accesses. The I/O and memory accesses must fall in one window of 2^WIN_LOG2 bytes, which is 32 bytes by default. The block drives DEVSEL#, TRDY# and STOP# for every cycle it claims. It always claims with medium decode timing. It ends any attempt at a second data phase with a disconnect.

A small configuration header inside the block holds the identity words, the command register, the status register and two base registers, one for I/O and one for memory. The header answers configuration reads and writes by itself. I/O and memory accesses go to a register-port back end. The back end receives the window offset, the byte enables and the write data, and it returns read data with a one-cycle ready strobe. The number of wait states therefore depends on the back end.

A busy input from an external EEPROM loader makes the block answer every configuration access with a retry. Memory Read Multiple and Memory Read Line are treated as plain memory reads. Memory Write and Invalidate is treated as a plain memory write.

Top module: `pcit_target`

## Requirements
- R1: DEVSEL# goes low in the second clock of the data phase of every claimed cycle, that is, two rising edges after the edge that samples the address.
- R2: A configuration cycle is claimed only when all of the following hold:
  - IDSEL is high.
  - C/BE# is 1010 (read) or 1011 (write).
  - AD[1:0] is 00.

  AD[7:2] selects the header word, and AD[31:8] has no effect. The header words are:
  - Word 0: {device id, vendor id}.
  - Word 1: {status, command}.
  - Word 2: class/revision.
  - Word 4: I/O base, whose bit 0 reads 1.
  - Word 5: memory base.
- R3: A configuration cycle asserts TRDY# in the third clock of the data phase.
- R4: If FRAME# is still low when TRDY# is asserted, STOP# is asserted with it. After that data transfer, TRDY# stays high until the cycle ends.
- R5: While the EEPROM busy input is high, a configuration cycle gets DEVSEL#, then STOP#, and never TRDY#.
- R6: I/O commands (0010 read, 0011 write) are claimed only when command bit 0 (I/O enable) is set. The address must fall in the I/O window, and all 32 address bits are compared.
- R7: Memory commands are claimed only when command bit 1 (memory enable) is set and the address falls in the memory window. The reads are 0110, 1100 and 1110. The writes are 0111 and 1111.
- R8: No other command code is claimed, even when its address hits a window. An I/O command in the memory window is not claimed, and neither is a memory command in the I/O window.
- R9: The back end and the configuration header both receive the byte enables active-high (bit n is the inverse of C/BE#[n]). Only the enabled byte lanes are written, so 8-, 16- and 32-bit writes all work.
- R10: Status bit 7 always reads 1. An address phase is recognised even when it directly follows another target's last data phase with no idle clock between them.
- R11: For I/O and memory cycles, TRDY# goes low in the clock after the back end's ready strobe is sampled. Read data is presented on the bus while TRDY# is low.
- R12: After a claimed cycle ends, DEVSEL#, TRDY# and STOP# are driven high for exactly one clock (control enable high). After that clock they are released (control enable low).
- R13: After reset the control and data enables are low, the command register reads 0 and both base registers read 0 apart from the constant I/O bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data bus as seen by the target |
| ad_o | output | 32 | Read data driven onto the address/data bus |
| ad_oe | output | 1 | Enable for ad_o |
| cbe_n | input | 4 | Command during the address phase, active-low byte enables during the data phase |
| frame_n | input | 1 | FRAME# |
| irdy_n | input | 1 | IRDY# |
| idsel | input | 1 | Configuration select |
| devsel_n | output | 1 | DEVSEL# value |
| trdy_n | output | 1 | TRDY# value |
| stop_n | output | 1 | STOP# value |
| ctl_oe | output | 1 | Enable for DEVSEL#, TRDY# and STOP# |
| eep_busy | input | 1 | High while the EEPROM load is in progress |
| be_req | output | 1 | Back-end access request |
| be_wr | output | 1 | Back-end access is a write |
| be_mem | output | 1 | Back-end access came through the memory window |
| be_addr | output | WIN_LOG2 | Byte offset in the window |
| be_ben | output | 4 | Active-high byte enables |
| be_wdata | output | 32 | Write data |
| be_rdata | input | 32 | Read data from the back end |
| be_ack | input | 1 | One-cycle ready strobe from the back end |

## Verification
A wrong state register shows at the bus control pins within one or two clocks. A missed decode step moves the DEVSEL# edge away from the second data-phase clock. A lost disconnect flag leaves STOP# high beside TRDY#. A stuck disconnect or retry state keeps the control enable high past the one turnaround clock. Header faults surface in the read data of the next configuration read. Byte-lane faults surface in the back-end contents read back through the memory window a few cycles later. Missing back-to-back recognition shows as an unclaimed cycle straight after a foreign data phase.

// File: rtl/pcit_pkg.sv
`timescale 1ns/1ps
package pcit_pkg;

   typedef enum logic [2:0] {
      S_IDLE, S_DEC, S_CFG, S_WAIT, S_XFER, S_DISC, S_RETRY, S_TURN
   } pcit_state_e;

   localparam logic [3:0] C_IO_RD   = 4'b0010;
   localparam logic [3:0] C_IO_WR   = 4'b0011;
   localparam logic [3:0] C_MEM_RD  = 4'b0110;
   localparam logic [3:0] C_MEM_WR  = 4'b0111;
   localparam logic [3:0] C_CFG_RD  = 4'b1010;
   localparam logic [3:0] C_CFG_WR  = 4'b1011;
   localparam logic [3:0] C_MEM_RDM = 4'b1100;
   localparam logic [3:0] C_MEM_RDL = 4'b1110;
   localparam logic [3:0] C_MEM_WRI = 4'b1111;

   localparam logic [5:0] IDX_ID      = 6'd0;
   localparam logic [5:0] IDX_CMDSTAT = 6'd1;
   localparam logic [5:0] IDX_CLASS   = 6'd2;
   localparam logic [5:0] IDX_IOBAR   = 6'd4;
   localparam logic [5:0] IDX_MEMBAR  = 6'd5;

   // medium devsel timing (bits 10:9 = 01) and fast back-to-back capable (bit 7)
   localparam logic [15:0] STATUS_CONST = 16'h0280;

endpackage

// File: rtl/pcit_cfg_hdr.sv
`timescale 1ns/1ps
module pcit_cfg_hdr
   import pcit_pkg::*;
#(
   parameter int          WIN_LOG2  = 5,
   parameter bit          HAS_MEM   = 1'b1,
   parameter logic [15:0] VEND_ID   = 16'h0001,
   parameter logic [15:0] DEV_ID    = 16'h0002,
   parameter logic [31:0] CLASS_REV = 32'h0200_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [5:0]          idx,
   input  logic [3:0]          ben,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   output logic                io_en,
   output logic                mem_en,
   output logic [31:WIN_LOG2]  io_win,
   output logic [31:WIN_LOG2]  mem_win
);

   localparam int          LANES = 4;
   localparam logic [31:0] WMASK = ~((32'd1 << WIN_LOG2) - 32'd1);

   if (WIN_LOG2 < 2 || WIN_LOG2 > 16) begin : g_bad_win
      $error("pcit_cfg_hdr: WIN_LOG2 must lie in 2..16");
   end

   logic [31:0] io_raw;
   logic [31:0] mem_raw;
   logic [1:0]  cmd_q;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [7:0] io_q;
      logic [7:0] mem_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            io_q  <= 8'h00;
            mem_q <= 8'h00;
         end else if (wr && ben[b]) begin
            if (idx == IDX_IOBAR)  io_q  <= wdata[8*b +: 8];
            if (idx == IDX_MEMBAR) mem_q <= wdata[8*b +: 8];
         end
      end
      assign io_raw[8*b +: 8]  = io_q;
      assign mem_raw[8*b +: 8] = mem_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cmd_q <= 2'b00;
      else if (wr && ben[0] && idx == IDX_CMDSTAT) cmd_q <= wdata[1:0];
   end

   logic [31:0] mem_rd;
   if (HAS_MEM) begin : g_mem
      assign mem_en  = cmd_q[1];
      assign mem_win = mem_raw[31:WIN_LOG2];
      assign mem_rd  = mem_raw & WMASK;
   end else begin : g_no_mem
      assign mem_en  = 1'b0;
      assign mem_win = '0;
      assign mem_rd  = 32'h0;
   end

   assign io_en  = cmd_q[0];
   assign io_win = io_raw[31:WIN_LOG2];

   always_comb begin
      unique case (idx)
         IDX_ID:      rdata = {DEV_ID, VEND_ID};
         IDX_CMDSTAT: rdata = {STATUS_CONST, 14'h0, cmd_q};
         IDX_CLASS:   rdata = CLASS_REV;
         IDX_IOBAR:   rdata = (io_raw & WMASK) | 32'h1;
         IDX_MEMBAR:  rdata = mem_rd;
         default:     rdata = 32'h0;
      endcase
   end

   AST_STATUS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == IDX_CMDSTAT) |-> rdata[23]) else $error("status bit 7 lost"); // R10

endmodule

// File: rtl/pcit_decode.sv
`timescale 1ns/1ps
module pcit_decode
   import pcit_pkg::*;
#(
   parameter int WIN_LOG2 = 5
) (
   input  logic [31:WIN_LOG2] addr_hi,
   input  logic [1:0]         addr_lo,
   input  logic [3:0]         cmd,
   input  logic               sel,
   input  logic               io_en,
   input  logic               mem_en,
   input  logic [31:WIN_LOG2] io_win,
   input  logic [31:WIN_LOG2] mem_win,
   output logic               hit_cfg,
   output logic               hit_io,
   output logic               hit_mem,
   output logic               is_wr
);

   logic io_cmd, mrd_cmd, mwr_cmd, cfg_cmd;

   always_comb begin
      io_cmd  = (cmd == C_IO_RD) || (cmd == C_IO_WR);
      // advanced read and write commands fold into the basic ones
      mrd_cmd = (cmd == C_MEM_RD) || (cmd == C_MEM_RDM) || (cmd == C_MEM_RDL);
      mwr_cmd = (cmd == C_MEM_WR) || (cmd == C_MEM_WRI);
      cfg_cmd = (cmd == C_CFG_RD) || (cmd == C_CFG_WR);
      hit_cfg = sel && cfg_cmd && (addr_lo == 2'b00);
      hit_io  = io_en && io_cmd && (addr_hi == io_win);
      hit_mem = mem_en && (mrd_cmd || mwr_cmd) && (addr_hi == mem_win);
      is_wr   = (cmd == C_IO_WR) || mwr_cmd || (cmd == C_CFG_WR);
   end

   AST_ONE_SPACE: assert final ($countones({hit_io, hit_mem}) <= 1) else $error("double hit"); // R8

endmodule

// File: rtl/pcit_target.sv
`timescale 1ns/1ps
module pcit_target
   import pcit_pkg::*;
#(
   parameter int          WIN_LOG2  = 5,
   parameter bit          HAS_MEM   = 1'b1,
   parameter logic [15:0] VEND_ID   = 16'h0001,
   parameter logic [15:0] DEV_ID    = 16'h0002,
   parameter logic [31:0] CLASS_REV = 32'h0200_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [31:0]         ad_i,
   output logic [31:0]         ad_o,
   output logic                ad_oe,
   input  logic [3:0]          cbe_n,
   input  logic                frame_n,
   input  logic                irdy_n,
   input  logic                idsel,
   output logic                devsel_n,
   output logic                trdy_n,
   output logic                stop_n,
   output logic                ctl_oe,
   input  logic                eep_busy,
   output logic                be_req,
   output logic                be_wr,
   output logic                be_mem,
   output logic [WIN_LOG2-1:0] be_addr,
   output logic [3:0]          be_ben,
   output logic [31:0]         be_wdata,
   input  logic [31:0]         be_rdata,
   input  logic                be_ack
);

   if (WIN_LOG2 < 2 || WIN_LOG2 > 16) begin : g_bad_win
      $error("pcit_target: WIN_LOG2 must lie in 2..16");
   end

   pcit_state_e st;
   logic        frame_q, sel_q, cfg_q, mem_q, wr_q, stop_q;
   logic [31:0] addr_q, rd_q;
   logic [3:0]  cmd_q;
   logic        start_w, cfg_wr;
   logic        hit_cfg, hit_io, hit_mem, is_wr;
   logic        io_en, mem_en;
   logic [31:WIN_LOG2] io_win, mem_win;
   logic [31:0] cfg_rdata;

   // an address phase is a fresh low FRAME#, also straight after a foreign data phase
   assign start_w = (st == S_IDLE || st == S_TURN) && !frame_n && frame_q;
   assign cfg_wr  = (st == S_XFER) && !irdy_n && cfg_q && wr_q;

   pcit_cfg_hdr #(
      .WIN_LOG2(WIN_LOG2), .HAS_MEM(HAS_MEM),
      .VEND_ID(VEND_ID), .DEV_ID(DEV_ID), .CLASS_REV(CLASS_REV)
   ) hdr_i (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(addr_q[7:2]),
      .ben(~cbe_n), .wdata(ad_i), .rdata(cfg_rdata),
      .io_en(io_en), .mem_en(mem_en), .io_win(io_win), .mem_win(mem_win)
   );

   pcit_decode #(.WIN_LOG2(WIN_LOG2)) dec_i (
      .addr_hi(addr_q[31:WIN_LOG2]), .addr_lo(addr_q[1:0]), .cmd(cmd_q), .sel(sel_q),
      .io_en(io_en), .mem_en(mem_en), .io_win(io_win), .mem_win(mem_win),
      .hit_cfg(hit_cfg), .hit_io(hit_io), .hit_mem(hit_mem), .is_wr(is_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         frame_q <= 1'b1;
         addr_q  <= '0;
         cmd_q   <= '0;
         sel_q   <= 1'b0;
         cfg_q   <= 1'b0;
         mem_q   <= 1'b0;
         wr_q    <= 1'b0;
         stop_q  <= 1'b0;
         rd_q    <= '0;
      end else begin
         frame_q <= frame_n;
         unique case (st)
            S_IDLE, S_TURN: begin
               if (start_w) begin
                  st     <= S_DEC;
                  addr_q <= ad_i;
                  cmd_q  <= cbe_n;
                  sel_q  <= idsel;
               end else begin
                  st <= S_IDLE;
               end
            end
            S_DEC: begin
               cfg_q  <= hit_cfg;
               mem_q  <= hit_mem;
               wr_q   <= is_wr;
               stop_q <= 1'b0;
               if (hit_cfg)               st <= S_CFG;
               else if (hit_io || hit_mem) st <= S_WAIT;
               else                        st <= S_IDLE;
            end
            S_CFG: begin
               if (eep_busy) begin
                  st <= S_RETRY;
               end else begin
                  st     <= S_XFER;
                  rd_q   <= cfg_rdata;
                  stop_q <= !frame_n;
               end
            end
            S_WAIT: begin
               if (be_ack) begin
                  st     <= S_XFER;
                  rd_q   <= be_rdata;
                  stop_q <= !frame_n;
               end
            end
            S_XFER: begin
               if (!irdy_n) st <= frame_n ? S_TURN : S_DISC;
            end
            S_DISC, S_RETRY: begin
               if (frame_n) st <= S_TURN;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      devsel_n = !(st == S_CFG || st == S_WAIT || st == S_XFER || st == S_DISC || st == S_RETRY);
      trdy_n   = !(st == S_XFER);
      stop_n   = !((st == S_XFER && stop_q) || st == S_DISC || st == S_RETRY);
      ctl_oe   = !(st == S_IDLE || st == S_DEC);
      ad_oe    = (st == S_XFER) && !wr_q;
      ad_o     = rd_q;
      be_req   = (st == S_WAIT) && (!wr_q || !irdy_n);
      be_wr    = wr_q;
      be_mem   = mem_q;
      be_addr  = addr_q[WIN_LOG2-1:0];
      be_ben   = ~cbe_n;
      be_wdata = ad_i;
   end

   AST_DEVSEL_MEDIUM: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |-> $past(start_w, 2)) else $error("devsel timing"); // R1
   AST_CFG_TRDY_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(trdy_n) && cfg_q) |-> $past(start_w, 3)) else $error("cfg trdy timing"); // R3
   AST_NO_SECOND_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && !irdy_n && !frame_n) |=> (trdy_n && !stop_n)) else $error("burst taken"); // R4
   AST_RETRY_NO_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CFG && eep_busy) |=> (trdy_n && !stop_n)) else $error("retry"); // R5
   AST_TRDY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(trdy_n) && !cfg_q) |-> $past(be_ack)) else $error("trdy without ack"); // R11
   AST_TURN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(devsel_n) |-> (ctl_oe && trdy_n && stop_n)) else $error("turnaround"); // R12

endmodule

// File: tb/pcit_target_tb_top.sv
`timescale 1ns/1ps
module pcit_target_tb_top;

   localparam logic [15:0] T_VEND  = 16'h1A2B;
   localparam logic [15:0] T_DEV   = 16'h3C4D;
   localparam logic [31:0] T_CLASS = 32'h0200_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad_i = '0;
   logic [31:0] ad_o;
   logic        ad_oe;
   logic [3:0]  cbe_n = 4'hF;
   logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, eep_busy = 1'b0;
   logic        devsel_n, trdy_n, stop_n, ctl_oe;
   logic        be_req, be_wr, be_mem, be_ack;
   logic [4:0]  be_addr;
   logic [3:0]  be_ben;
   logic [31:0] be_wdata, be_rdata;

   always #2 clk = ~clk;

   pcit_target #(
      .WIN_LOG2(5), .HAS_MEM(1'b1),
      .VEND_ID(T_VEND), .DEV_ID(T_DEV), .CLASS_REV(T_CLASS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
      .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
      .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
      .eep_busy(eep_busy), .be_req(be_req), .be_wr(be_wr), .be_mem(be_mem),
      .be_addr(be_addr), .be_ben(be_ben), .be_wdata(be_wdata),
      .be_rdata(be_rdata), .be_ack(be_ack)
   );

   int n_chk = 0;
   int n_err = 0;
   int bw_wait = 1;
   int bcnt = 0;
   logic [31:0] bmem [8];

   bit          r_claim, r_stop_trdy, r_retry, r_turn_ok, r_rel_ok;
   int          r_kdev, r_ktrdy, r_extra;
   logic [31:0] r_rd;

   // back-end model: ready strobe after bw_wait request clocks
   initial begin
      be_ack = 1'b0;
      be_rdata = '0;
      for (int i = 0; i < 8; i++) bmem[i] = 32'h0;
      forever begin
         @(negedge clk);
         if (be_ack) begin
            be_ack = 1'b0;
            bcnt = 0;
         end else if (be_req) begin
            bcnt++;
            if (bcnt >= bw_wait) begin
               be_ack = 1'b1;
               if (be_wr) begin
                  for (int b = 0; b < 4; b++)
                     if (be_ben[b]) bmem[be_addr[4:2]][8*b +: 8] = be_wdata[8*b +: 8];
               end else begin
                  be_rdata = bmem[be_addr[4:2]];
               end
            end
         end else begin
            bcnt = 0;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus cycle as initiator; results land in the r_* variables
   task automatic bus_op(input logic [3:0] cmd, input logic [31:0] addr, input logic [3:0] ben_n,
                         input logic [31:0] wd, input bit cfg, input bit burst, input bit fb2b);
      int  k;
      bit  done;
      r_claim = 0; r_kdev = 0; r_ktrdy = 0; r_stop_trdy = 0; r_retry = 0;
      r_rd = '0; r_extra = 0; r_turn_ok = 0; r_rel_ok = 0;
      @(negedge clk);
      if (fb2b) begin
         frame_n = 1'b0; ad_i = 32'h7000_0000; cbe_n = 4'b0110; idsel = 1'b0;
         @(negedge clk);
         frame_n = 1'b1; irdy_n = 1'b0; ad_i = 32'h0; cbe_n = 4'h0;
         @(negedge clk);
         irdy_n = 1'b1;
      end
      frame_n = 1'b0; ad_i = addr; cbe_n = cmd; idsel = cfg;
      @(negedge clk);
      k = 1; done = 0;
      cbe_n = ben_n; ad_i = wd; irdy_n = 1'b0; frame_n = !burst; idsel = 1'b0;
      while (!done && k <= 14) begin
         if (!devsel_n && r_kdev == 0) r_kdev = k;
         if (!trdy_n) begin
            r_ktrdy = k; r_stop_trdy = !stop_n; r_rd = ad_o; done = 1;
         end else if (!stop_n) begin
            r_retry = 1; done = 1;
         end else begin
            @(negedge clk);
            k++;
         end
      end
      r_claim = (r_kdev != 0);
      if (!done) begin
         frame_n = 1'b1; irdy_n = 1'b1;
         @(negedge clk);
         r_rel_ok = !ctl_oe;
      end else begin
         @(negedge clk);
         if (burst) begin
            if (!trdy_n) r_extra++;
            frame_n = 1'b1;
            @(negedge clk);
            if (!trdy_n) r_extra++;
         end
         r_turn_ok = ctl_oe && devsel_n && trdy_n && stop_n;
         irdy_n = 1'b1;
         @(negedge clk);
         r_rel_ok = !ctl_oe;
      end
      ad_i = '0; cbe_n = 4'hF; frame_n = 1'b1;
   endtask

   task automatic t_reset();
      chk("R13 ctl_oe after reset", {31'h0, ctl_oe}, 32'h0);
      chk("R13 ad_oe after reset", {31'h0, ad_oe}, 32'h0);
      chk("R13 devsel high after reset", {31'h0, devsel_n}, 32'h1);
   endtask

   task automatic t_cfg_ids();
      bus_op(4'b1010, 32'h0000_0000, 4'h0, 32'h0, 1, 0, 0);
      chk("R1 cfg devsel clock", r_kdev, 2);
      chk("R3 cfg trdy clock", r_ktrdy, 3);
      chk("R2 id word", r_rd, {T_DEV, T_VEND});
      chk("R12 turnaround driven", {31'h0, r_turn_ok}, 32'h1);
      chk("R12 released", {31'h0, r_rel_ok}, 32'h1);
      bus_op(4'b1010, 32'h0000_0004, 4'h0, 32'h0, 1, 0, 0);
      chk("R10 status bit 7 with R13 command zero", r_rd, 32'h0280_0000);
      bus_op(4'b1010, 32'h0000_0010, 4'h0, 32'h0, 1, 0, 0);
      chk("R13 io base reset", r_rd, 32'h0000_0001);
      bus_op(4'b1010, 32'h0000_0008, 4'h0, 32'h0, 1, 0, 0);
      chk("R2 class word", r_rd, T_CLASS);
   endtask

   task automatic t_cfg_decode();
      bus_op(4'b1010, 32'h0000_0001, 4'h0, 32'h0, 1, 0, 0);
      chk("R2 ad10 01 not claimed", {31'h0, r_claim}, 32'h0);
      bus_op(4'b1010, 32'h0000_0000, 4'h0, 32'h0, 0, 0, 0);
      chk("R2 idsel low not claimed", {31'h0, r_claim}, 32'h0);
      bus_op(4'b1010, 32'hABCD_E704, 4'h0, 32'h0, 1, 0, 0);
      chk("R2 upper bits ignored", r_rd, 32'h0280_0000);
   endtask

   task automatic t_io();
      bus_op(4'b1011, 32'h0000_0010, 4'h0, 32'h0000_1000, 1, 0, 0);
      bus_op(4'b0010, 32'h0000_1008, 4'h0, 32'h0, 0, 0, 0);
      chk("R6 io before enable not claimed", {31'h0, r_claim}, 32'h0);
      bus_op(4'b1011, 32'h0000_0004, 4'h0, 32'h0000_0001, 1, 0, 0);
      bus_op(4'b1010, 32'h0000_0010, 4'h0, 32'h0, 1, 0, 0);
      chk("R2 io base readback", r_rd, 32'h0000_1001);
      bw_wait = 6;
      bus_op(4'b0011, 32'h0000_1008, 4'h0, 32'hCAFE_F00D, 0, 0, 0);
      chk("R1 io devsel clock", r_kdev, 2);
      chk("R11 io write trdy after six waits", r_ktrdy, 8);
      bus_op(4'b0010, 32'h0000_1008, 4'h0, 32'h0, 0, 0, 0);
      chk("R6 io read data", r_rd, 32'hCAFE_F00D);
      chk("R11 io read trdy clock", r_ktrdy, 8);
      bw_wait = 1;
      bus_op(4'b0010, 32'h0000_1020, 4'h0, 32'h0, 0, 0, 0);
      chk("R6 outside window", {31'h0, r_claim}, 32'h0);
      bus_op(4'b0010, 32'h8000_1008, 4'h0, 32'h0, 0, 0, 0);
      chk("R6 high bit compared", {31'h0, r_claim}, 32'h0);
   endtask

   task automatic t_mem();
      bus_op(4'b1011, 32'h0000_0014, 4'h0, 32'h4000_0000, 1, 0, 0);
      bus_op(4'b1011, 32'h0000_0004, 4'h0, 32'h0000_0003, 1, 0, 0);
      bw_wait = 2;
      bus_op(4'b1111, 32'h4000_0010, 4'h0, 32'h5A5A_1234, 0, 0, 0);
      chk("R7 write-invalidate claimed", {31'h0, r_claim}, 32'h1);
      bus_op(4'b1100, 32'h4000_0010, 4'h0, 32'h0, 0, 0, 0);
      chk("R7 read-multiple data", r_rd, 32'h5A5A_1234);
      chk("R11 mem trdy clock", r_ktrdy, 4);
      bus_op(4'b1110, 32'h4000_0010, 4'h0, 32'h0, 0, 0, 0);
      chk("R7 read-line data", r_rd, 32'h5A5A_1234);
      bw_wait = 1;
   endtask

   task automatic t_badcmd();
      bus_op(4'b0100, 32'h4000_0010, 4'h0, 32'h0, 0, 0, 0);
      chk("R8 reserved cmd in mem window", {31'h0, r_claim}, 32'h0);
      bus_op(4'b1000, 32'h0000_1008, 4'h0, 32'h0, 0, 0, 0);
      chk("R8 reserved cmd in io window", {31'h0, r_claim}, 32'h0);
      bus_op(4'b0010, 32'h4000_0010, 4'h0, 32'h0, 0, 0, 0);
      chk("R8 io cmd in mem window", {31'h0, r_claim}, 32'h0);
      bus_op(4'b0110, 32'h0000_1008, 4'h0, 32'h0, 0, 0, 0);
      chk("R8 mem cmd in io window", {31'h0, r_claim}, 32'h0);
   endtask

   task automatic t_bytes();
      bus_op(4'b0111, 32'h4000_0014, 4'h0, 32'hAAAA_AAAA, 0, 0, 0);
      bus_op(4'b0111, 32'h4000_0014, 4'b1011, 32'h1122_3344, 0, 0, 0);
      bus_op(4'b0110, 32'h4000_0014, 4'h0, 32'h0, 0, 0, 0);
      chk("R9 single byte lane write", r_rd, 32'hAA22_AAAA);
      bus_op(4'b0111, 32'h4000_0014, 4'b1100, 32'h5566_7788, 0, 0, 0);
      bus_op(4'b0110, 32'h4000_0014, 4'h0, 32'h0, 0, 0, 0);
      chk("R9 halfword write", r_rd, 32'hAA22_7788);
      bus_op(4'b1011, 32'h0000_0010, 4'b1101, 32'h0000_2000, 1, 0, 0);
      bus_op(4'b1010, 32'h0000_0010, 4'h0, 32'h0, 1, 0, 0);
      chk("R9 cfg byte lane write", r_rd, 32'h0000_2001);
      bus_op(4'b1011, 32'h0000_0010, 4'h0, 32'h0000_1000, 1, 0, 0);
   endtask

   task automatic t_burst();
      bus_op(4'b0011, 32'h0000_1008, 4'h0, 32'h0BAD_BEEF, 0, 1, 0);
      chk("R4 io stop with trdy", {31'h0, r_stop_trdy}, 32'h1);
      chk("R4 io no second phase", r_extra, 0);
      chk("R12 io turnaround after disconnect", {31'h0, r_turn_ok}, 32'h1);
      bus_op(4'b1010, 32'h0000_0000, 4'h0, 32'h0, 1, 1, 0);
      chk("R4 cfg stop with trdy", {31'h0, r_stop_trdy}, 32'h1);
      chk("R3 cfg burst trdy clock", r_ktrdy, 3);
      chk("R4 cfg no second phase", r_extra, 0);
   endtask

   task automatic t_retry();
      eep_busy = 1'b1;
      bus_op(4'b1010, 32'h0000_0000, 4'h0, 32'h0, 1, 0, 0);
      chk("R5 retry claimed", {31'h0, r_claim}, 32'h1);
      chk("R5 retry stop", {31'h0, r_retry}, 32'h1);
      chk("R5 retry no trdy", r_ktrdy, 0);
      chk("R12 turnaround after retry", {31'h0, r_turn_ok}, 32'h1);
      eep_busy = 1'b0;
      bus_op(4'b1010, 32'h0000_0000, 4'h0, 32'h0, 1, 0, 0);
      chk("R5 after busy clears", r_rd, {T_DEV, T_VEND});
   endtask

   task automatic t_b2b();
      bus_op(4'b1010, 32'h0000_0004, 4'h0, 32'h0, 1, 0, 1);
      chk("R10 b2b cfg claimed", {31'h0, r_claim}, 32'h1);
      chk("R10 b2b cfg data", r_rd, 32'h0280_0003);
      bus_op(4'b0010, 32'h0000_1008, 4'h0, 32'h0, 0, 0, 1);
      chk("R10 b2b io data", r_rd, 32'h0BAD_BEEF);
      chk("R1 b2b devsel clock", r_kdev, 2);
   endtask

   bit fin = 0;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_ids();
      t_cfg_decode();
      t_io();
      t_mem();
      t_badcmd();
      t_bytes();
      t_burst();
      t_retry();
      t_b2b();
      fin = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!fin) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule